// File: doc/BRIEF.md
# Interval Bound Operand Selector

This block sits in front of a pair of directed-rounding arithmetic units, one rounding toward minus infinity (the lower unit) and one rounding toward plus infinity (the upper unit). It receives two intervals, A with bounds `a_lo`/`a_hi` and B with bounds `b_lo`/`b_hi`, each bound an IEEE double. It also receives an operation code and a pass bit. From the sign and zero pattern of the four bounds it decides which A bound and which B bound each unit consumes. It drives the four select bits and the routed operands, so each unit always takes its left operand from A and its right operand from B.

For add and subtract the pairing is fixed. Multiply is split into nine cases by the sign class of each interval. When both intervals straddle zero, multiply takes two passes: the pass bit picks which pair of products is formed, and a later stage takes the hull of the two results. Division by an interval that excludes zero is split into six cases. Division by an interval that contains zero still routes the operands for the finite part of the result, and it raises a flag so that a result stage inserts the infinities or the empty-interval code. The block is purely combinational: no clock, no reset and no state.

Top module: `ivsel_operand_select`

## Requirements
- R1: For add (op = 0) the selects are lower unit (A lower, B lower) and upper unit (A upper, B upper). Select encoding throughout: 0 picks the lower bound of an interval and 1 picks its upper bound. `need_post` is 0.
- R2: For subtract (op = 1) the lower unit gets (A lower, B upper) and the upper unit gets (A upper, B lower). `need_post` is 0.
- R3: A bound is zero when bits 62:0 are all zero, whatever the sign bit (bit 63). So both +0 and -0 count as zero, and a subnormal counts as nonzero. A bound is negative only when bit 63 is set and it is not zero.
- R4: For multiply and for the numerator of a divide, an interval is classed nonnegative if its lower bound is not negative. Otherwise it is nonpositive if its upper bound is negative or zero. Otherwise it is mixed. The classes are tested in that order.
- R5: For multiply (op = 2), eight of the nine class pairs (A,B) take one pass with these (lower pair; upper pair): (nonneg,nonneg) (a_lo,b_lo; a_hi,b_hi); (nonneg,mixed) (a_hi,b_lo; a_hi,b_hi); (nonneg,nonpos) (a_hi,b_lo; a_lo,b_hi); (mixed,nonneg) (a_lo,b_hi; a_hi,b_hi); (mixed,nonpos) (a_hi,b_lo; a_lo,b_lo); (nonpos,nonneg) (a_lo,b_hi; a_hi,b_lo); (nonpos,mixed) (a_lo,b_hi; a_lo,b_lo); (nonpos,nonpos) (a_hi,b_hi; a_lo,b_lo).
- R6: For multiply with both intervals mixed, `need_post` is 1. Pass 0 gives (a_lo,b_hi; a_lo,b_lo) and pass 1 gives (a_hi,b_lo; a_hi,b_hi).
- R7: For divide (op = 3), the divisor class is tested in this order: strictly positive if b_lo is neither negative nor zero, strictly negative if b_hi is negative, otherwise it contains zero. For a strictly positive divisor: numerator nonneg (a_lo,b_hi; a_hi,b_lo), mixed (a_lo,b_lo; a_hi,b_lo), nonpos (a_lo,b_lo; a_hi,b_hi). For a strictly negative divisor: nonneg (a_hi,b_hi; a_lo,b_lo), mixed (a_hi,b_hi; a_lo,b_hi), nonpos (a_hi,b_lo; a_lo,b_hi). In all six cases `need_post` is 0.
- R8: For divide by a divisor that contains zero, `need_post` is 1. The numerator is tested first for strictly positive (a_lo neither negative nor zero), which gives (a_lo,b_hi; a_lo,b_lo). It is then tested for strictly negative (a_hi negative), which gives (a_hi,b_lo; a_hi,b_hi). Otherwise the selects are (a_lo,b_lo; a_hi,b_hi).
- R9: `need_post` is 1 only in the cases of R6 and R8. The pass bit has no effect on any output outside the R6 case.
- R10: Each routed operand output equals the bound its select bit picks: `lo_a`/`hi_a` carry a bound of A, and `lo_b`/`hi_b` carry a bound of B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_lo | input | 64 | Lower bound of interval A |
| a_hi | input | 64 | Upper bound of interval A |
| b_lo | input | 64 | Lower bound of interval B |
| b_hi | input | 64 | Upper bound of interval B |
| op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 divide |
| pass | input | 1 | Pass of a two-pass multiply (0 first, 1 second) |
| sel_lo_a | output | 1 | A bound for the lower unit (0 lower, 1 upper) |
| sel_lo_b | output | 1 | B bound for the lower unit |
| sel_hi_a | output | 1 | A bound for the upper unit |
| sel_hi_b | output | 1 | B bound for the upper unit |
| need_post | output | 1 | Case needs a later result-selection step |
| lo_a | output | 64 | Left operand of the lower unit |
| lo_b | output | 64 | Right operand of the lower unit |
| hi_a | output | 64 | Left operand of the upper unit |
| hi_b | output | 64 | Right operand of the upper unit |

## Verification
Two decisions interact in the same evaluation: the zero decode of a signed zero or a subnormal, and the interval class it feeds. For example, a -0 lower bound must classify an interval as nonnegative, while a negative subnormal upper bound must make a divisor strictly negative. The bench provokes this by sweeping every bound through +0, -0, positive and negative normals and positive and negative subnormals, under all four operations and both pass values. It judges each vector against tables indexed by classes derived from real-number comparisons in the bench.

// File: rtl/ivsel_pkg.sv
package ivsel_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_e;

    // sign class with non-strict edges (zero joins either side)
    typedef enum logic [1:0] {
        SPAN_NONNEG = 2'd0,
        SPAN_MIXED  = 2'd1,
        SPAN_NONPOS = 2'd2
    } span_e;

    // sign class with strict edges (zero is its own class)
    typedef enum logic [1:0] {
        STRICT_POS  = 2'd0,
        STRICT_NEG  = 2'd1,
        STRICT_ZERO = 2'd2
    } strict_e;

    // 0 picks the lower bound, 1 the upper bound
    typedef struct packed {
        logic lo_a;
        logic lo_b;
        logic hi_a;
        logic hi_b;
    } pick_t;

endpackage

// File: rtl/ivsel_bound_flags.sv
module ivsel_bound_flags #(
    parameter int FP_W = 64
) (
    input  logic [FP_W-1:0] bound,
    output logic            is_neg,
    output logic            is_zero
);
    localparam int SIGN_BIT = FP_W - 1;

    always_comb begin
        is_zero = ~|bound[SIGN_BIT-1:0];
        is_neg  = bound[SIGN_BIT] & ~is_zero;
    end
endmodule

// File: rtl/ivsel_span_class.sv
module ivsel_span_class
    import ivsel_pkg::*;
(
    input  logic    lo_neg,
    input  logic    lo_zero,
    input  logic    hi_neg,
    input  logic    hi_zero,
    output span_e   span,
    output strict_e strict
);
    always_comb begin
        if (!lo_neg)                span = SPAN_NONNEG;
        else if (hi_neg || hi_zero) span = SPAN_NONPOS;
        else                        span = SPAN_MIXED;

        if (!lo_neg && !lo_zero)    strict = STRICT_POS;
        else if (hi_neg)            strict = STRICT_NEG;
        else                        strict = STRICT_ZERO;
    end
endmodule

// File: rtl/ivsel_pick_table.sv
module ivsel_pick_table
    import ivsel_pkg::*;
(
    input  op_e     op,
    input  logic    pass,
    input  span_e   a_span,
    input  strict_e a_strict,
    input  span_e   b_span,
    input  strict_e b_strict,
    output pick_t   pick,
    output logic    need_post
);
    pick_t mul_pick;
    logic  mul_post;
    pick_t div_pick;
    logic  div_post;

    always_comb begin
        mul_post = 1'b0;
        mul_pick = '{lo_a: 1'b0, lo_b: 1'b0, hi_a: 1'b1, hi_b: 1'b1};
        unique case (a_span)
            SPAN_NONNEG: begin
                unique case (b_span)
                    SPAN_NONNEG: mul_pick = 4'b0011;
                    SPAN_MIXED:  mul_pick = 4'b1011;
                    SPAN_NONPOS: mul_pick = 4'b1001;
                    default:     mul_pick = 4'b0011;
                endcase
            end
            SPAN_MIXED: begin
                unique case (b_span)
                    SPAN_NONNEG: mul_pick = 4'b0111;
                    SPAN_MIXED: begin
                        mul_post = 1'b1;
                        mul_pick = pass ? 4'b1011 : 4'b0100;
                    end
                    SPAN_NONPOS: mul_pick = 4'b1000;
                    default:     mul_pick = 4'b0011;
                endcase
            end
            SPAN_NONPOS: begin
                unique case (b_span)
                    SPAN_NONNEG: mul_pick = 4'b0110;
                    SPAN_MIXED:  mul_pick = 4'b0100;
                    SPAN_NONPOS: mul_pick = 4'b1100;
                    default:     mul_pick = 4'b0011;
                endcase
            end
            default: mul_pick = 4'b0011;
        endcase
    end

    always_comb begin
        div_post = 1'b0;
        div_pick = 4'b0011;
        unique case (b_strict)
            STRICT_POS: begin
                unique case (a_span)
                    SPAN_NONNEG: div_pick = 4'b0110;
                    SPAN_MIXED:  div_pick = 4'b0010;
                    SPAN_NONPOS: div_pick = 4'b0011;
                    default:     div_pick = 4'b0011;
                endcase
            end
            STRICT_NEG: begin
                unique case (a_span)
                    SPAN_NONNEG: div_pick = 4'b1100;
                    SPAN_MIXED:  div_pick = 4'b1101;
                    SPAN_NONPOS: div_pick = 4'b1001;
                    default:     div_pick = 4'b0011;
                endcase
            end
            STRICT_ZERO: begin
                div_post = 1'b1;
                unique case (a_strict)
                    STRICT_POS:  div_pick = 4'b0100;
                    STRICT_NEG:  div_pick = 4'b1011;
                    STRICT_ZERO: div_pick = 4'b0011;
                    default:     div_pick = 4'b0011;
                endcase
            end
            default: div_pick = 4'b0011;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_ADD: begin pick = 4'b0011; need_post = 1'b0;     end
            OP_SUB: begin pick = 4'b0110; need_post = 1'b0;     end
            OP_MUL: begin pick = mul_pick; need_post = mul_post; end
            OP_DIV: begin pick = div_pick; need_post = div_post; end
            default: begin pick = 4'b0011; need_post = 1'b0;    end
        endcase
    end

    // R5 R7: single-pass multiply and divide feed the two units different pairs
    always_comb begin
        if ((op == OP_MUL || op == OP_DIV) && !need_post) begin
            distinct_pairs_chk: assert ({pick.lo_a, pick.lo_b} != {pick.hi_a, pick.hi_b})
                else $error("distinct_pairs_chk");
        end
    end
endmodule

// File: rtl/ivsel_operand_mux.sv
module ivsel_operand_mux
    import ivsel_pkg::*;
#(
    parameter int FP_W  = 64,
    parameter int UNITS = 2
) (
    input  logic [FP_W-1:0] a_lo,
    input  logic [FP_W-1:0] a_hi,
    input  logic [FP_W-1:0] b_lo,
    input  logic [FP_W-1:0] b_hi,
    input  pick_t           pick,
    output logic [FP_W-1:0] unit_a [UNITS],
    output logic [FP_W-1:0] unit_b [UNITS]
);
    logic [UNITS-1:0] sel_a;
    logic [UNITS-1:0] sel_b;

    assign sel_a = {pick.hi_a, pick.lo_a};
    assign sel_b = {pick.hi_b, pick.lo_b};

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        assign unit_a[u] = sel_a[u] ? a_hi : a_lo;
        assign unit_b[u] = sel_b[u] ? b_hi : b_lo;
    end
endmodule

// File: rtl/ivsel_operand_select.sv
module ivsel_operand_select
    import ivsel_pkg::*;
#(
    parameter int FP_W = 64
) (
    input  logic [FP_W-1:0] a_lo,
    input  logic [FP_W-1:0] a_hi,
    input  logic [FP_W-1:0] b_lo,
    input  logic [FP_W-1:0] b_hi,
    input  logic [1:0]      op,
    input  logic            pass,
    output logic            sel_lo_a,
    output logic            sel_lo_b,
    output logic            sel_hi_a,
    output logic            sel_hi_b,
    output logic            need_post,
    output logic [FP_W-1:0] lo_a,
    output logic [FP_W-1:0] lo_b,
    output logic [FP_W-1:0] hi_a,
    output logic [FP_W-1:0] hi_b
);
    localparam int NBOUND = 4;
    localparam int UNITS  = 2;

    logic [FP_W-1:0] bounds [NBOUND];
    logic [NBOUND-1:0] neg_f;
    logic [NBOUND-1:0] zero_f;

    assign bounds[0] = a_lo;
    assign bounds[1] = a_hi;
    assign bounds[2] = b_lo;
    assign bounds[3] = b_hi;

    for (genvar k = 0; k < NBOUND; k++) begin : g_flags
        ivsel_bound_flags #(.FP_W(FP_W)) u_flags (
            .bound   (bounds[k]),
            .is_neg  (neg_f[k]),
            .is_zero (zero_f[k])
        );
    end

    span_e   a_span, b_span;
    strict_e a_strict, b_strict;

    ivsel_span_class u_cls_a (
        .lo_neg (neg_f[0]), .lo_zero (zero_f[0]),
        .hi_neg (neg_f[1]), .hi_zero (zero_f[1]),
        .span   (a_span),   .strict  (a_strict)
    );

    ivsel_span_class u_cls_b (
        .lo_neg (neg_f[2]), .lo_zero (zero_f[2]),
        .hi_neg (neg_f[3]), .hi_zero (zero_f[3]),
        .span   (b_span),   .strict  (b_strict)
    );

    op_e   op_q;
    pick_t pick;

    assign op_q = op_e'(op);

    ivsel_pick_table u_table (
        .op        (op_q),
        .pass      (pass),
        .a_span    (a_span),
        .a_strict  (a_strict),
        .b_span    (b_span),
        .b_strict  (b_strict),
        .pick      (pick),
        .need_post (need_post)
    );

    logic [FP_W-1:0] unit_a [UNITS];
    logic [FP_W-1:0] unit_b [UNITS];

    ivsel_operand_mux #(.FP_W(FP_W), .UNITS(UNITS)) u_mux (
        .a_lo   (a_lo),
        .a_hi   (a_hi),
        .b_lo   (b_lo),
        .b_hi   (b_hi),
        .pick   (pick),
        .unit_a (unit_a),
        .unit_b (unit_b)
    );

    assign sel_lo_a = pick.lo_a;
    assign sel_lo_b = pick.lo_b;
    assign sel_hi_a = pick.hi_a;
    assign sel_hi_b = pick.hi_b;
    assign lo_a     = unit_a[0];
    assign hi_a     = unit_a[1];
    assign lo_b     = unit_b[0];
    assign hi_b     = unit_b[1];

    always_comb begin
        // R9
        if (need_post) begin
            post_op_chk: assert (op_q == OP_MUL || op_q == OP_DIV)
                else $error("post_op_chk");
        end
        // R8
        if (op_q == OP_DIV && (neg_f[2] || zero_f[2]) && !neg_f[3]) begin
            div_zero_post_chk: assert (need_post)
                else $error("div_zero_post_chk");
        end
        // R1
        if (op_q == OP_ADD) begin
            add_route_chk: assert (lo_a == a_lo && lo_b == b_lo && hi_a == a_hi && hi_b == b_hi)
                else $error("add_route_chk");
        end
        // R2
        if (op_q == OP_SUB) begin
            sub_route_chk: assert (lo_a == a_lo && lo_b == b_hi && hi_a == a_hi && hi_b == b_lo)
                else $error("sub_route_chk");
        end
        // R6
        if (op_q == OP_MUL && a_span == SPAN_MIXED && b_span == SPAN_MIXED && !pass) begin
            mul_first_pass_chk: assert (lo_a == a_lo && hi_a == a_lo && need_post)
                else $error("mul_first_pass_chk");
        end
    end
endmodule

// File: tb/ivsel_operand_select_bench.sv
module ivsel_operand_select_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [63:0] a_lo, a_hi, b_lo, b_hi;
    logic [1:0]  op;
    logic        pass;
    logic        sel_lo_a, sel_lo_b, sel_hi_a, sel_hi_b, need_post;
    logic [63:0] lo_a, lo_b, hi_a, hi_b;

    ivsel_operand_select u_ivsel_operand_select (
        .a_lo (a_lo), .a_hi (a_hi), .b_lo (b_lo), .b_hi (b_hi),
        .op (op), .pass (pass),
        .sel_lo_a (sel_lo_a), .sel_lo_b (sel_lo_b),
        .sel_hi_a (sel_hi_a), .sel_hi_b (sel_hi_b),
        .need_post (need_post),
        .lo_a (lo_a), .lo_b (lo_b), .hi_a (hi_a), .hi_b (hi_b)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // +2.5, -1.5, +0, -0, +min subnormal, -min subnormal
    function automatic logic [63:0] sample_val(int code);
        case (code)
            0: return $realtobits(2.5);
            1: return $realtobits(-1.5);
            2: return 64'h0000_0000_0000_0000;
            3: return 64'h8000_0000_0000_0000;
            4: return 64'h0000_0000_0000_0001;
            default: return 64'h8000_0000_0000_0001;
        endcase
    endfunction

    // 0 nonneg, 1 mixed, 2 nonpos (R4)
    function automatic int span_of(real lo, real hi);
        if (lo >= 0.0) return 0;
        if (hi <= 0.0) return 2;
        return 1;
    endfunction

    // 0 strictly positive, 1 strictly negative, 2 otherwise
    function automatic int strict_of(real lo, real hi);
        if (lo > 0.0) return 0;
        if (hi < 0.0) return 1;
        return 2;
    endfunction

    // expected {lo_a,lo_b,hi_a,hi_b}, post flag and requirement tag
    task automatic expect_sel(input int o, input bit p, input real x1, input real x2,
                              input real y1, input real y2,
                              output logic [3:0] e, output bit post, output string tag);
        int sa, sb, tb_, ta;
        sa = span_of(x1, x2);
        sb = span_of(y1, y2);
        ta = strict_of(x1, x2);
        tb_ = strict_of(y1, y2);
        post = 1'b0;
        if (o == 0) begin e = 4'b0011; tag = "R1"; end
        else if (o == 1) begin e = 4'b0110; tag = "R2"; end
        else if (o == 2) begin
            tag = "R4 R5";
            case (sa * 3 + sb)
                0: e = 4'b0011;
                1: e = 4'b1011;
                2: e = 4'b1001;
                3: e = 4'b0111;
                4: begin e = p ? 4'b1011 : 4'b0100; post = 1'b1; tag = "R6"; end
                5: e = 4'b1000;
                6: e = 4'b0110;
                7: e = 4'b0100;
                default: e = 4'b1100;
            endcase
        end else begin
            tag = "R7";
            if (tb_ == 0) e = (sa == 0) ? 4'b0110 : (sa == 1) ? 4'b0010 : 4'b0011;
            else if (tb_ == 1) e = (sa == 0) ? 4'b1100 : (sa == 1) ? 4'b1101 : 4'b1001;
            else begin
                post = 1'b1;
                tag = "R8";
                e = (ta == 0) ? 4'b0100 : (ta == 1) ? 4'b1011 : 4'b0011;
            end
        end
    endtask

    task automatic run_vec(input int o, input bit p, input int c0, input int c1,
                           input int c2, input int c3);
        logic [3:0] e;
        bit post;
        string tag;
        logic [63:0] x1, x2, y1, y2, ela, elb, eha, ehb;
        x1 = sample_val(c0); x2 = sample_val(c1);
        y1 = sample_val(c2); y2 = sample_val(c3);
        @(posedge clk);
        #1;
        a_lo = x1; a_hi = x2; b_lo = y1; b_hi = y2; op = 2'(o); pass = p;
        expect_sel(o, p, $bitstoreal(x1), $bitstoreal(x2), $bitstoreal(y1), $bitstoreal(y2),
                   e, post, tag);
        ela = e[3] ? x2 : x1;
        elb = e[2] ? y2 : y1;
        eha = e[1] ? x2 : x1;
        ehb = e[0] ? y2 : y1;
        @(negedge clk);
        checks++;
        if ({sel_lo_a, sel_lo_b, sel_hi_a, sel_hi_b} != e || need_post != post) begin
            fails++;
            $display("FAIL %s R3 R9 op=%0d pass=%0d codes=%0d%0d%0d%0d sel=%b post=%b expected sel=%b post=%b",
                     tag, o, p, c0, c1, c2, c3,
                     {sel_lo_a, sel_lo_b, sel_hi_a, sel_hi_b}, need_post, e, post);
        end
        checks++;
        if (lo_a != ela || lo_b != elb || hi_a != eha || hi_b != ehb) begin
            fails++;
            $display("FAIL R10 op=%0d codes=%0d%0d%0d%0d got %h %h %h %h expected %h %h %h %h",
                     o, c0, c1, c2, c3, lo_a, lo_b, hi_a, hi_b, ela, elb, eha, ehb);
        end
    endtask

    initial begin
        a_lo = '0; a_hi = '0; b_lo = '0; b_hi = '0; op = 2'd0; pass = 1'b0;
        @(negedge clk);
        // R1: all-zero inputs with add give the straight pairing
        checks++;
        if ({sel_lo_a, sel_lo_b, sel_hi_a, sel_hi_b, need_post} != 5'b00110) begin
            fails++;
            $display("FAIL R1 initial sel=%b post=%b expected sel=0011 post=0",
                     {sel_lo_a, sel_lo_b, sel_hi_a, sel_hi_b}, need_post);
        end
        for (int o = 0; o < 4; o++)
            for (int p = 0; p < 2; p++)
                for (int c0 = 0; c0 < 6; c0++)
                    for (int c1 = 0; c1 < 6; c1++)
                        for (int c2 = 0; c2 < 6; c2++)
                            for (int c3 = 0; c3 < 6; c3++)
                                run_vec(o, p[0], c0, c1, c2, c3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule